// File: doc/BRIEF.md
# Delay Memory Sweep Controller

This block owns the port of a single-port delay memory with 14-bit words. It does three jobs. It can sweep every word to zero. It can run a self test that fills the memory with an alternating bit pattern and then reads every word back to confirm it. It can also perform a single read or write on behalf of a host.

Both sweeps walk the addresses in ascending order through one counter and one memory datapath. A clear sweep finishes even if its request is dropped, and only a separate cancel input can stop it. A self test always runs to the end. While either sweep runs, host access requests are dropped.

Every reset starts a clear sweep. After a clear sweep completes, another one waits until two word-clock strobes have been seen, which guarantees at least one full word period between clears.

Top module: `dm_sweep_ctrl`

## Requirements
- R1: While `rst_n` is low, `ready`, `test_pass` and `test_active` are 0. Releasing reset starts a clear sweep that writes zero to all 2^ADDR_W words, and `ready` rises on the ADDR_W-th... precisely on the 2^ADDR_W-th rising edge after release.
- R2: With `zero_req` high, `zero_cancel` low and the controller idle, a clear sweep starts on the next edge and `ready` drops. Every word becomes 0, and `ready` rises 2^ADDR_W+1 edges after the request was first sampled. Dropping `zero_req` partway through does not stop the sweep.
- R3: Raising `zero_cancel` during a clear sweep stops it at once: no further words are written and `ready` stays 0. While `zero_cancel` is high, no clear sweep starts, even with `zero_req` held high.
- R4: After a clear sweep completes, a new clear sweep can start only on the edge after the second `word_stb` pulse has been sampled.
- R5: A one-cycle `test_start` pulse sampled while idle starts a self test. The write pass stores 0x2AAA at even and 0x1555 at odd addresses when `pat_sel` = 1, and 0x1555 at even and 0x2AAA at odd addresses when `pat_sel` = 0. The test then reads every word back and completes 2×2^ADDR_W+2 edges after the pulse was sampled.
- R6: `test_pass` is cleared when a test starts. At completion it is set to 1 only if every word read back equals the word written, and to 0 otherwise.
- R7: `test_active` goes high when a test is requested and clears itself on the edge where the test completes, the same edge on which `ready` rises. Neither `zero_cancel` nor `zero_req` shortens a running test.
- R8: A one-cycle `wr_sel` pulse while idle writes `host_wdata` at `host_addr`, with `ready` high on the 3rd edge after the pulse was sampled. A one-cycle `rd_sel` pulse places the addressed word on `rd_data` with `ready` high on the 4th edge.
- R9: `rd_sel` and `wr_sel` pulses that arrive during a clear or test sweep are dropped. No memory access follows, and `rd_data` and `ready` are left unchanged.
- R10: Only the low ADDR_W bits of the 16-bit `host_addr` are decoded. Bit 15 has no effect on which word is accessed.
- R11: If `test_start` and `zero_req` are sampled on the same idle edge, the self test runs first. A clear sweep starts on the edge after the test completes.
- R12: Within a sweep, successive memory accesses step the address up by one, starting at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| zero_req | input | 1 | Level request for a clear sweep |
| zero_cancel | input | 1 | Stops a clear sweep and blocks new ones while high |
| test_start | input | 1 | Pulse that requests a self test |
| pat_sel | input | 1 | Self-test pattern phase, latched at test start |
| rd_sel | input | 1 | Pulse that requests a host read |
| wr_sel | input | 1 | Pulse that requests a host write |
| host_addr | input | 16 | Host word address; the bits above ADDR_W are ignored |
| host_wdata | input | DATA_W | Host write data |
| word_stb | input | 1 | One-cycle strobe once per word-clock period |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |
| rd_data | output | DATA_W | Last word fetched by a host read |
| ready | output | 1 | High once the last operation has completed |
| test_pass | output | 1 | Result of the last self test |
| test_active | output | 1 | Self-test request bit; clears itself at completion |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The timing is fixed by counting edges from the one that first samples a stimulus:

| Operation | `ready` rises on edge |
|-----------|-----------------------|
| Host write | 3 |
| Host read | 4 |
| Clear sweep | 2^ADDR_W+1 |
| Self test | 2×2^ADDR_W+2 |
| Clear started by reset release | 2^ADDR_W |

A common wait routine samples `ready` on the falling edge just before the due edge and expects 0, then on the falling edge just after it and expects 1. A result that comes one cycle early or one cycle late therefore fails.

Memory contents are checked in the bench's own memory model, against zero or against the alternating words computed in the bench. Drops, cancels and the strobe guard are checked by holding the request and confirming that `ready` and the memory stay unchanged for a fixed window.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CLR  = 3'd1,
    S_TWR  = 3'd2,
    S_TRD  = 3'd3,
    S_TCHK = 3'd4,
    S_HWR  = 3'd5,
    S_HRD  = 3'd6,
    S_HRDW = 3'd7
  } state_t;

  // Alternating bit mask of width w (w <= 32); odd=1 sets odd bit positions.
  function automatic logic [31:0] alt_bits(input int w, input logic odd);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < w; i++) begin
      r[i] = ((i % 2) == 1) == odd;
    end
    return r;
  endfunction

endpackage

// File: rtl/dm_sweep_ctr.sv
module dm_sweep_ctr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || inc) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = &cnt_q;

endmodule

// File: rtl/dm_verify.sv
module dm_verify #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] rdata,
  input  logic              finish,
  output logic              pass
);

  logic              chk_q;
  logic [DATA_W-1:0] exp_q;
  logic              bad_q, bad_d;
  logic              pass_q, pass_d;
  logic              bad_now;

  assign bad_now = chk_q && (rdata != exp_q);

  always_comb begin
    bad_d  = bad_q | bad_now;
    pass_d = pass_q;
    if (start) begin
      bad_d  = 1'b0;
      pass_d = 1'b0;
    end else if (finish) begin
      pass_d = !(bad_q | bad_now);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      exp_q  <= '0;
      bad_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      chk_q  <= rd_issue;
      bad_q  <= bad_d;
      pass_q <= pass_d;
      if (rd_issue) begin
        exp_q <= exp_word;
      end
    end
  end

  assign pass = pass_q;

endmodule

// File: rtl/dm_stb_guard.sv
module dm_stb_guard #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stb,
  output logic blocked
);

  localparam int GW = $clog2(GAP + 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm) begin
      cnt_d = GW'(GAP);
    end else if (stb && (cnt_q != '0)) begin
      cnt_d = cnt_q - GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm || stb) begin
      cnt_q <= cnt_d;
    end
  end

  assign blocked = (cnt_q != '0);

endmodule

// File: rtl/dm_sweep_ctrl.sv
module dm_sweep_ctrl
  import dm_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int ADDR_W    = 15,
  parameter int HOST_AW   = 16,
  parameter int GUARD_STB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_req,
  input  logic               zero_cancel,
  input  logic               test_start,
  input  logic               pat_sel,
  input  logic               rd_sel,
  input  logic               wr_sel,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               word_stb,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               ready,
  output logic               test_pass,
  output logic               test_active,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);

  localparam logic [31:0]       EVEN32 = alt_bits(DATA_W, 1'b0);
  localparam logic [31:0]       ODD32  = alt_bits(DATA_W, 1'b1);
  localparam logic [DATA_W-1:0] EVEN_W = EVEN32[DATA_W-1:0];
  localparam logic [DATA_W-1:0] ODD_W  = ODD32[DATA_W-1:0];

  state_t state_q, state_d;
  logic              pat_q;
  logic              test_bit_q, test_bit_d;
  logic              rd_pend_q, rd_pend_d;
  logic              wr_pend_q, wr_pend_d;
  logic [ADDR_W-1:0] haddr_q;
  logic [DATA_W-1:0] hwdata_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              ready_q, ready_d;

  logic              ctr_clr, ctr_inc, ctr_last;
  logic [ADDR_W-1:0] ctr;
  logic              guard_arm, guard_blk;
  logic              test_go, test_end, rd_cap;
  logic              wr_take, rd_take;
  logic              sweeping, host_cap;
  logic [DATA_W-1:0] pat_word;
  logic              unused_hi;

  assign unused_hi = ^host_addr[HOST_AW-1:ADDR_W];
  assign sweeping  = (state_q == S_CLR) || (state_q == S_TWR) ||
                     (state_q == S_TRD) || (state_q == S_TCHK);
  assign host_cap  = (rd_sel || wr_sel) && !sweeping;
  assign pat_word  = (ctr[0] ^ pat_q) ? ODD_W : EVEN_W;

  dm_sweep_ctr #(.W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .cnt   (ctr),
    .last  (ctr_last)
  );

  dm_stb_guard #(.GAP(GUARD_STB)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (guard_arm),
    .stb     (word_stb),
    .blocked (guard_blk)
  );

  dm_verify #(.DATA_W(DATA_W)) u_vfy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (test_go),
    .rd_issue (state_q == S_TRD),
    .exp_word (pat_word),
    .rdata    (mem_rdata),
    .finish   (state_q == S_TCHK),
    .pass     (test_pass)
  );

  // Sequencing
  always_comb begin
    state_d   = state_q;
    ready_d   = ready_q;
    ctr_clr   = 1'b0;
    ctr_inc   = 1'b0;
    guard_arm = 1'b0;
    test_go   = 1'b0;
    test_end  = 1'b0;
    wr_take   = 1'b0;
    rd_take   = 1'b0;
    rd_cap    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (test_start || test_bit_q) begin
          state_d = S_TWR;
          ctr_clr = 1'b1;
          test_go = 1'b1;
          ready_d = 1'b0;
        end else if (zero_req && !zero_cancel && !guard_blk) begin
          state_d = S_CLR;
          ctr_clr = 1'b1;
          ready_d = 1'b0;
        end else if (wr_pend_q) begin
          state_d = S_HWR;
          wr_take = 1'b1;
          ready_d = 1'b0;
        end else if (rd_pend_q) begin
          state_d = S_HRD;
          rd_take = 1'b1;
          ready_d = 1'b0;
        end
      end
      S_CLR: begin
        if (zero_cancel) begin
          state_d = S_IDLE;
        end else if (ctr_last) begin
          state_d   = S_IDLE;
          ready_d   = 1'b1;
          guard_arm = 1'b1;
          ctr_clr   = 1'b1;
        end else begin
          ctr_inc = 1'b1;
        end
      end
      S_TWR: begin
        if (ctr_last) begin
          state_d = S_TRD;
          ctr_clr = 1'b1;
        end else begin
          ctr_inc = 1'b1;
        end
      end
      S_TRD: begin
        if (ctr_last) begin
          state_d = S_TCHK;
          ctr_clr = 1'b1;
        end else begin
          ctr_inc = 1'b1;
        end
      end
      S_TCHK: begin
        state_d  = S_IDLE;
        ready_d  = 1'b1;
        test_end = 1'b1;
      end
      S_HWR: begin
        state_d = S_IDLE;
        ready_d = 1'b1;
      end
      S_HRD: begin
        state_d = S_HRDW;
      end
      S_HRDW: begin
        state_d = S_IDLE;
        ready_d = 1'b1;
        rd_cap  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Request bits
  always_comb begin
    test_bit_d = test_bit_q;
    if (test_end) begin
      test_bit_d = 1'b0;
    end else if (test_start) begin
      test_bit_d = 1'b1;
    end
    wr_pend_d = wr_pend_q;
    if (wr_take) begin
      wr_pend_d = 1'b0;
    end else if (wr_sel && !sweeping) begin
      wr_pend_d = 1'b1;
    end
    rd_pend_d = rd_pend_q;
    if (rd_take) begin
      rd_pend_d = 1'b0;
    end else if (rd_sel && !sweeping) begin
      rd_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_CLR;
      ready_q    <= 1'b0;
      test_bit_q <= 1'b0;
      wr_pend_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ready_q    <= ready_d;
      test_bit_q <= test_bit_d;
      wr_pend_q  <= wr_pend_d;
      rd_pend_q  <= rd_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q     <= 1'b0;
      haddr_q   <= '0;
      hwdata_q  <= '0;
      rd_data_q <= '0;
    end else begin
      if (test_go) begin
        pat_q <= pat_sel;
      end
      if (host_cap) begin
        haddr_q  <= host_addr[ADDR_W-1:0];
        hwdata_q <= host_wdata;
      end
      if (rd_cap) begin
        rd_data_q <= mem_rdata;
      end
    end
  end

  // Memory port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ctr;
    mem_wdata = '0;
    unique case (state_q)
      S_CLR: begin
        mem_en = !zero_cancel;
        mem_we = 1'b1;
      end
      S_TWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pat_word;
      end
      S_TRD: begin
        mem_en = 1'b1;
      end
      S_HWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = haddr_q;
        mem_wdata = hwdata_q;
      end
      S_HRD: begin
        mem_en   = 1'b1;
        mem_addr = haddr_q;
      end
      default: begin
        mem_en = 1'b0;
      end
    endcase
  end

  assign rd_data     = rd_data_q;
  assign ready       = ready_q;
  assign test_active = test_bit_q;

endmodule

// File: rtl/dm_sweep_ctrl_chk.sv
module dm_sweep_ctrl_chk
  import dm_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input state_t            state,
  input logic              pat,
  input logic              zero_cancel,
  input logic              test_start,
  input logic              test_active,
  input logic              ready,
  input logic              test_pass,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  localparam logic [31:0] E32 = alt_bits(DATA_W, 1'b0);
  localparam logic [31:0] O32 = alt_bits(DATA_W, 1'b1);

  logic [DATA_W-1:0] exp_pat;
  assign exp_pat = (mem_addr[0] ^ pat) ? O32[DATA_W-1:0] : E32[DATA_W-1:0];

  // R12
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && state == S_CLR && $past(state) == S_CLR && mem_en && $past(mem_en))
      |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CLR && mem_en) |-> (mem_we && mem_wdata == '0));

  // R5
  pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TWR) |-> (mem_en && mem_we && mem_wdata == exp_pat));

  // R3
  cancel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && zero_cancel && !test_start && !test_active) |=> state != S_CLR);

  // R7
  test_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_active) |-> ready);

  // R6
  pass_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(test_pass)) |-> ($past(state) == S_IDLE || $past(state) == S_TCHK));

  // R8
  host_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(state) == S_HRDW) |-> (ready && rd_data == $past(mem_rdata)));

endmodule

bind dm_sweep_ctrl dm_sweep_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state_q),
  .pat         (pat_q),
  .zero_cancel (zero_cancel),
  .test_start  (test_start),
  .test_active (test_active),
  .ready       (ready),
  .test_pass   (test_pass),
  .rd_data     (rd_data),
  .mem_rdata   (mem_rdata),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata)
);

// File: tb/sim_dm_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_dm_sweep_ctrl;

  localparam int DW = 14;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          zero_req, zero_cancel, test_start, pat_sel, rd_sel, wr_sel, word_stb;
  logic [15:0]   host_addr;
  logic [DW-1:0] host_wdata, mem_rdata, rd_data, mem_wdata;
  logic          ready, test_pass, test_active, mem_en, mem_we;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [N];
  logic          fill_en, fault_en;
  logic [AW-1:0] fault_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dm_sweep_ctrl #(.DATA_W(DW), .ADDR_W(AW), .HOST_AW(16), .GUARD_STB(2)) u0 (
    .clk(clk), .rst_n(rst_n), .zero_req(zero_req), .zero_cancel(zero_cancel),
    .test_start(test_start), .pat_sel(pat_sel), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .word_stb(word_stb),
    .mem_rdata(mem_rdata), .rd_data(rd_data), .ready(ready), .test_pass(test_pass),
    .test_active(test_active), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Memory model: synchronous single port, one-cycle read latency
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < N; i++) mem[i] <= DW'(14'h2000 | i);
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr] ^ ((fault_en && mem_addr == fault_addr) ? DW'(1) : DW'(0));
    end
  end

  function automatic logic [DW-1:0] pat_word(input logic p, input int a);
    return ((a % 2 == 1) ^ p) ? 14'h2AAA : 14'h1555;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drop_pulses();
    test_start = 1'b0; rd_sel = 1'b0; wr_sel = 1'b0; word_stb = 1'b0;
  endtask

  // Called at the negedge where the stimulus was applied; ready must rise on edge k.
  task automatic wait_done(input int k, input string req);
    for (int i = 0; i < k - 1; i++) begin
      @(negedge clk);
      if (i == 0) drop_pulses();
    end
    chk(req, "ready before due edge", int'(ready), 0);
    @(negedge clk);
    drop_pulses();
    chk(req, "ready at due edge", int'(ready), 1);
  endtask

  function automatic int count_zero_bad(input int lo, input int hi);
    int b = 0;
    for (int i = lo; i < hi; i++) if (mem[i] != '0) b++;
    return b;
  endfunction

  function automatic int count_fill_bad(input int lo, input int hi);
    int b = 0;
    for (int i = lo; i < hi; i++) if (mem[i] != DW'(14'h2000 | i)) b++;
    return b;
  endfunction

  function automatic int count_pat_bad(input logic p);
    int b = 0;
    for (int i = 0; i < N; i++) if (mem[i] != pat_word(p, i)) b++;
    return b;
  endfunction

  task automatic prefill();
    @(negedge clk); fill_en = 1'b1;
    @(negedge clk); fill_en = 1'b0;
  endtask

  task automatic two_strobes();
    for (int j = 0; j < 2; j++) begin
      @(negedge clk); word_stb = 1'b1;
      @(negedge clk); word_stb = 1'b0;
    end
  endtask

  task automatic run_test(input logic p, input int exp_pass, input string req);
    @(negedge clk); pat_sel = p; test_start = 1'b1;
    @(negedge clk); drop_pulses();
    chk("R7", "test_active after request", int'(test_active), 1);
    wait_done(2 * N + 1, req);
    chk(req, "pattern words", count_pat_bad(p), 0);
    chk("R6", "test_pass", int'(test_pass), exp_pass);
    chk("R7", "test_active self-clear", int'(test_active), 0);
  endtask

  initial begin
    rst_n = 1'b0; zero_req = 1'b0; zero_cancel = 1'b0; pat_sel = 1'b0;
    host_addr = '0; host_wdata = '0; fill_en = 1'b0; fault_en = 1'b0; fault_addr = '0;
    drop_pulses();
    repeat (2) @(negedge clk);
    fill_en = 1'b1;
    @(negedge clk); fill_en = 1'b0;
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "test_pass in reset", int'(test_pass), 0);
    chk("R1", "test_active in reset", int'(test_active), 0);
    rst_n = 1'b1;
    wait_done(N, "R1");
    chk("R1", "words not zero after reset sweep", count_zero_bad(0, N), 0);

    // R4: strobe guard with zero held high
    zero_req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4", "ready held, no clear before strobes", int'(ready), 1);
    word_stb = 1'b1;
    @(negedge clk); word_stb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4", "ready held after one strobe", int'(ready), 1);
    word_stb = 1'b1;
    wait_done(N + 2, "R4");
    zero_req = 1'b0;

    // R8 / R10: host write and read
    @(negedge clk); host_addr = 16'h0003; host_wdata = 14'h1234; wr_sel = 1'b1;
    wait_done(3, "R8");
    chk("R8", "mem[3] after write", int'(mem[3]), 'h1234);
    @(negedge clk); host_addr = 16'h8003; rd_sel = 1'b1;
    wait_done(4, "R10");
    chk("R10", "rd_data with bit15 set", int'(rd_data), 'h1234);
    @(negedge clk); host_addr = 16'h8007; host_wdata = 14'h0ABC; wr_sel = 1'b1;
    wait_done(3, "R10");
    chk("R10", "mem[7] via bit15 address", int'(mem[7]), 'h0ABC);

    // R5 / R6: both pattern phases, then a faulty word
    run_test(1'b1, 1, "R5");
    run_test(1'b0, 1, "R5");
    @(negedge clk); fault_en = 1'b1; fault_addr = AW'(9);
    run_test(1'b1, 0, "R6");
    @(negedge clk); fault_en = 1'b0;

    // R7: cancel during a test has no effect
    @(negedge clk); pat_sel = 1'b0; test_start = 1'b1;
    repeat (10) @(negedge clk);
    drop_pulses(); zero_cancel = 1'b1;
    repeat (10) @(negedge clk);
    zero_cancel = 1'b0;
    wait_done(2 * N + 2 - 20, "R7");
    chk("R7", "test_pass despite cancel", int'(test_pass), 1);

    // R2 / R9: request dropped mid-sweep; host pulses ignored
    two_strobes();
    prefill();
    @(negedge clk); zero_req = 1'b1;
    @(negedge clk); zero_req = 1'b0;
    repeat (3) @(negedge clk);
    host_addr = 16'h0014; host_wdata = 14'h3333; wr_sel = 1'b1; rd_sel = 1'b1;
    @(negedge clk); drop_pulses();
    wait_done(N - 4, "R2");
    chk("R2", "words not zero after dropped request", count_zero_bad(0, N), 0);
    repeat (6) @(negedge clk);
    chk("R9", "ready after ignored host pulses", int'(ready), 1);
    chk("R9", "rd_data unchanged", int'(rd_data), 'h1234);
    chk("R9", "mem[20] not written", int'(mem[20]), 0);

    // R3: cancel mid-sweep, then cancel blocks start
    two_strobes();
    prefill();
    @(negedge clk); zero_req = 1'b1;
    repeat (6) @(negedge clk);
    zero_cancel = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3", "ready after cancel", int'(ready), 0);
    chk("R3", "cleared head words", count_zero_bad(0, 5), 0);
    chk("R3", "untouched tail words", count_fill_bad(5, N), 0);
    repeat (40) @(negedge clk);
    chk("R3", "tail still untouched while cancel held", count_fill_bad(5, N), 0);
    zero_cancel = 1'b0;
    wait_done(N + 1, "R3");
    chk("R3", "words not zero after cancel release", count_zero_bad(0, N), 0);
    zero_req = 1'b0;

    // R11: test and zero sampled together
    two_strobes();
    prefill();
    @(negedge clk); zero_req = 1'b1; pat_sel = 1'b1; test_start = 1'b1;
    wait_done(2 * N + 2, "R11");
    chk("R11", "pattern present when test ends", count_pat_bad(1'b1), 0);
    chk("R11", "test_pass", int'(test_pass), 1);
    wait_done(N + 1, "R11");
    chk("R11", "words not zero after deferred clear", count_zero_bad(0, N), 0);
    zero_req = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog ALL actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule